// File: doc/BRIEF.md
# Session Identifier Tamper Seal

This block gives a configured device a session identifier that changes whenever the device is reconfigured or its boundary-scan debug pins show activity. Once configuration is reported done, the block takes four bytes from a true random number generator, joins them into a 32-bit identifier and marks it valid. No port writes the identifier. It can only be replaced by a fresh random capture.

The three boundary-scan pins (test clock, mode select and data in) are watched through synchronisers. Any edge on the test clock, or any change on mode select or data in, sets a tamper flag. The flag stays set until the next full reset. The same event also drops the identifier and starts a new capture. An operator can therefore note the identifier at the start of a session and compare it at the end. A new bitstream loaded in between, or any use of the debug port, shows up as a different value. The identifier is also presented as eight ASCII characters for a character display.

Top module: `sess_seal`

## Requirements
- R1: While reset is held and right after it is released, `id_valid_o` and `tamper_o` are 0 and `id_o` is 0.
- R2: While `cfg_done_i` is 1 and the identifier is not valid, each clock edge with `rnd_valid_i` high takes one byte. The first byte taken lands in bits 31:24 and the fourth in bits 7:0. `id_valid_o` and `id_o` update on the edge that takes the fourth byte.
- R3: Until the fourth byte is taken, `id_valid_o` is 0 and `id_o` reads 0. Cycles with `rnd_valid_i` low take no byte.
- R4: Bytes offered while `cfg_done_i` is 0 are discarded and count toward no identifier.
- R5: Once valid, the identifier does not change when further random bytes arrive. No input writes it.
- R6: A change on `tck_i`, `tms_i` or `tdi_i` passes through a two-flop synchroniser and is registered on the third clock edge after the change. It then sets `tamper_o`, drops `id_valid_o` and restarts capture. Bytes already gathered are discarded.
- R7: `tamper_o` stays 1 until `rst_ni` is asserted. Toggling `cfg_done_i` does not clear it.
- R8: On the edge after `cfg_done_i` falls, `id_valid_o` goes to 0. A later rise of `cfg_done_i` captures a new identifier from fresh bytes.
- R9: `id_chars_o[63-8k -: 8]` is the uppercase ASCII hex digit of nibble k of `id_o`, where k=0 is bits 31:28. While the identifier is invalid, every character is '-' (0x2D).
- R10: Debug pin levels held steady across reset are not treated as activity, even when they are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low full reset |
| cfg_done_i | input | 1 | Device configuration complete (level) |
| rnd_valid_i | input | 1 | Random byte present this cycle |
| rnd_byte_i | input | 8 | Random byte from the generator |
| tck_i | input | 1 | Observed debug test clock pin |
| tms_i | input | 1 | Observed debug mode select pin |
| tdi_i | input | 1 | Observed debug data in pin |
| id_o | output | 32 | Session identifier, 0 while invalid |
| id_valid_o | output | 1 | Identifier complete |
| tamper_o | output | 1 | Sticky debug-pin activity flag |
| id_chars_o | output | 64 | Identifier as eight ASCII hex characters |

## Verification
The first capture inserts an idle gap in the random stream. This tests whether the bytes are counted by their valid strobe rather than by clock cycles. Bytes sent before configuration completes, and bytes sent after the identifier is valid, check that neither can change the stored word. Each debug pin is toggled separately, once while the identifier is valid and once in the middle of a capture, to show that all three pins trip the seal and that a partial capture is thrown away. A configuration drop, and a reset with a debug pin held high, separate recapture from tamper clearing and from false trips at reset.

// File: rtl/sess_seal_pkg.sv
package sess_seal_pkg;
  localparam logic [7:0] CHAR_DASH = 8'h2D;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
    if (nib < 4'd10) nib_to_ascii = 8'h30 + {4'd0, nib};
    else             nib_to_ascii = 8'h37 + {4'd0, nib};
  endfunction
endpackage

// File: rtl/sess_pin_watch.sv
module sess_pin_watch #(
  parameter int PINS        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pins_i,
  output logic            event_o
);
  localparam int ARM_N = SYNC_STAGES + 1;
  localparam int ARM_W = $clog2(ARM_N + 1);

  logic [SYNC_STAGES-1:0][PINS-1:0] sync_q;
  logic [PINS-1:0]                  prev_q;
  logic [ARM_W-1:0]                 arm_q;
  logic                             armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '0;
    else         sync_q[0] <= pins_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  assign armed = (arm_q == ARM_W'(ARM_N));

  // hold off until prev_q holds a real sample, so reset levels are not edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (!armed) arm_q <= arm_q + ARM_W'(1);
    end
  end

  assign event_o = armed && (sync_q[SYNC_STAGES-1] != prev_q);

  a_r10_arm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> armed);
endmodule

// File: rtl/sess_id_collect.sv
module sess_id_collect #(
  parameter int BYTE_W   = 8,
  parameter int ID_BYTES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_done_i,
  input  logic                       evt_i,
  input  logic                       rnd_valid_i,
  input  logic [BYTE_W-1:0]          rnd_byte_i,
  output logic [BYTE_W*ID_BYTES-1:0] id_o,
  output logic                       valid_o
);
  localparam int ID_W  = BYTE_W * ID_BYTES;
  localparam int CNT_W = $clog2(ID_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ID_BYTES - 1);

  logic [ID_W-1:0]  acc_q, id_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q, take;

  assign take = cfg_done_i && !evt_i && !valid_q && rnd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      id_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (evt_i || !cfg_done_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (take) begin
      acc_q <= {acc_q[ID_W-BYTE_W-1:0], rnd_byte_i};
      if (cnt_q == LAST) begin
        id_q    <= {acc_q[ID_W-BYTE_W-1:0], rnd_byte_i};
        valid_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign id_o    = valid_q ? id_q : '0;
  assign valid_o = valid_q;

  a_r5_id_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(valid_q)) |-> $stable(id_q));
  a_r6_evt_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> !valid_q);
  a_r8_cfg_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_i |=> !valid_q);
  a_r3_valid_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(rnd_valid_i && cfg_done_i));
endmodule

// File: rtl/sess_hex_view.sv
module sess_hex_view
  import sess_seal_pkg::*;
#(
  parameter int ID_W = 32
) (
  input  logic [ID_W-1:0]   id_i,
  input  logic              valid_i,
  output logic [ID_W*2-1:0] chars_o
);
  localparam int NIBS = ID_W / 4;

  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    assign chars_o[ID_W*2-1-8*k -: 8] =
      valid_i ? nib_to_ascii(id_i[ID_W-1-4*k -: 4]) : CHAR_DASH;
  end
endmodule

// File: rtl/sess_seal.sv
module sess_seal #(
  parameter int BYTE_W      = 8,
  parameter int ID_BYTES    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_done_i,
  input  logic                         rnd_valid_i,
  input  logic [BYTE_W-1:0]            rnd_byte_i,
  input  logic                         tck_i,
  input  logic                         tms_i,
  input  logic                         tdi_i,
  output logic [BYTE_W*ID_BYTES-1:0]   id_o,
  output logic                         id_valid_o,
  output logic                         tamper_o,
  output logic [BYTE_W*ID_BYTES*2-1:0] id_chars_o
);
  localparam int ID_W = BYTE_W * ID_BYTES;

  logic pin_evt;
  logic tamper_q;

  sess_pin_watch #(.PINS(3), .SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i ({tck_i, tms_i, tdi_i}),
    .event_o(pin_evt)
  );

  sess_id_collect #(.BYTE_W(BYTE_W), .ID_BYTES(ID_BYTES)) u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_done_i (cfg_done_i),
    .evt_i      (pin_evt),
    .rnd_valid_i(rnd_valid_i),
    .rnd_byte_i (rnd_byte_i),
    .id_o       (id_o),
    .valid_o    (id_valid_o)
  );

  sess_hex_view #(.ID_W(ID_W)) u_hex (
    .id_i   (id_o),
    .valid_i(id_valid_o),
    .chars_o(id_chars_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tamper_q <= 1'b0;
    else if (pin_evt) tamper_q <= 1'b1;
  end

  assign tamper_o = tamper_q;

  a_r7_tamper_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tamper_q |=> tamper_q);
  a_r6_tamper_blocks_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tamper_q) |-> !id_valid_o);
endmodule

// File: tb/sess_seal_test.sv
`timescale 1ns/1ps
module sess_seal_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_done_i = 1'b0, rnd_valid_i = 1'b0;
  logic [7:0]  rnd_byte_i = '0;
  logic        tck_i = 1'b0, tms_i = 1'b1, tdi_i = 1'b0;
  logic [31:0] id_o;
  logic        id_valid_o, tamper_o;
  logic [63:0] id_chars_o;

  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  logic        vprev = 1'b0;

  always #2.5 clk = ~clk;

  sess_seal uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_done_i(cfg_done_i),
    .rnd_valid_i(rnd_valid_i), .rnd_byte_i(rnd_byte_i),
    .tck_i(tck_i), .tms_i(tms_i), .tdi_i(tdi_i),
    .id_o(id_o), .id_valid_o(id_valid_o), .tamper_o(tamper_o),
    .id_chars_o(id_chars_o)
  );

  function automatic logic [63:0] exp_chars(input logic [31:0] w, input logic v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) begin
      logic [3:0] n;
      n = w[31-4*k -: 4];
      r[63-8*k -: 8] = !v ? 8'h2D : (n < 10 ? 8'h30 + {4'd0, n} : 8'h41 + {4'd0, n} - 8'd10);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed_raw(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rnd_valid_i = 1'b1;
      rnd_byte_i  = w[31-8*i -: 8];
    end
    @(negedge clk);
    rnd_valid_i = 1'b0;
  endtask

  // driver: pushes the expected word, inserts an idle gap after byte two
  task automatic feed_id(input logic [31:0] w, input int gap);
    exp_q.push_back(w);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 2 && gap > 0) begin
        rnd_valid_i = 1'b0;
        repeat (gap) @(negedge clk);
        check(!id_valid_o && id_o == 0, "R3", {31'd0, id_valid_o, id_o}, 64'd0);
      end
      rnd_valid_i = 1'b1;
      rnd_byte_i  = w[31-8*i -: 8];
    end
    @(negedge clk);
    rnd_valid_i = 1'b0;
    idle(1);
  endtask

  // monitor: compare each new identifier against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && id_valid_o && !vprev) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected id", {32'd0, id_o}, 64'd0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(id_o == e, "R2", {32'd0, id_o}, {32'd0, e});
        check(id_chars_o == exp_chars(e, 1'b1), "R9", id_chars_o, exp_chars(e, 1'b1));
      end
    end
    vprev = rst_ni && id_valid_o;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    idle(3);
    check(!id_valid_o && !tamper_o && id_o == 0, "R1", {30'd0, id_valid_o, tamper_o, id_o}, 64'd0);
    rst_ni = 1'b1;
    idle(8);
    check(!tamper_o, "R10 tms held high", {63'd0, tamper_o}, 64'd0);
    check(!id_valid_o && id_o == 0, "R1", {31'd0, id_valid_o, id_o}, 64'd0);
    check(id_chars_o == exp_chars(0, 1'b0), "R9 dashes", id_chars_o, exp_chars(0, 1'b0));

    feed_raw(32'h1122_3344, 3);
    check(!id_valid_o, "R4", {63'd0, id_valid_o}, 64'd0);
    cfg_done_i = 1'b1;
    feed_id(32'hA53C_9F21, 2);
    check(id_valid_o && id_o == 32'hA53C_9F21, "R2", {32'd0, id_o}, {32'd0, 32'hA53C_9F21});

    held = id_o;
    feed_raw(32'hDEAD_BEEF, 4);
    idle(1);
    check(id_o == held && id_valid_o, "R5", {32'd0, id_o}, {32'd0, held});

    tck_i = 1'b1;
    idle(2);
    check(id_valid_o, "R6 sync delay", {63'd0, id_valid_o}, 64'd1);
    idle(1);
    check(tamper_o && !id_valid_o, "R6 tck", {62'd0, tamper_o, id_valid_o}, 64'd2);
    check(id_chars_o == exp_chars(0, 1'b0), "R9 invalid", id_chars_o, exp_chars(0, 1'b0));
    tck_i = 1'b0;
    idle(4);
    feed_id(32'h0F1E_2D3C, 0);

    tms_i = 1'b0;
    idle(4);
    check(!id_valid_o && id_o == 0, "R6 tms", {31'd0, id_valid_o, id_o}, 64'd0);
    feed_id(32'h7B6A_5948, 0);

    feed_raw(32'h9999_9999, 2);
    tdi_i = 1'b1;
    idle(4);
    check(!id_valid_o && tamper_o, "R6 tdi", {62'd0, tamper_o, id_valid_o}, 64'd2);
    feed_id(32'hC0DE_F00D, 0);

    cfg_done_i = 1'b0;
    idle(1);
    check(!id_valid_o, "R8 cfg drop", {63'd0, id_valid_o}, 64'd0);
    check(tamper_o, "R7 cfg toggle", {63'd0, tamper_o}, 64'd1);
    idle(2);
    cfg_done_i = 1'b1;
    feed_id(32'h3141_5926, 0);
    check(id_o != 32'hC0DE_F00D && id_valid_o, "R8 new id", {32'd0, id_o}, {32'd0, 32'h3141_5926});
    check(tamper_o, "R7 sticky", {63'd0, tamper_o}, 64'd1);

    rst_ni = 1'b0;
    idle(2);
    check(!tamper_o && !id_valid_o, "R7 reset clears", {62'd0, tamper_o, id_valid_o}, 64'd0);
    rst_ni = 1'b1;
    idle(6);
    check(!tamper_o, "R10 tdi held high", {63'd0, tamper_o}, 64'd0);
    check(exp_q.size() == 0, "R2 all ids seen", 64'(exp_q.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule